// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of a 14-bit serial-input digital-to-analog converter. A host writes a code over three wires: an active-low chip select that frames the transfer, a serial clock, and a data line. The block assembles the incoming bits in a shift register and moves the finished word into a parallel code latch. The latch output drives the converter core and is the only value the rest of the chip sees.

The word moves into the latch under an active-low load input. If the load input is tied low, every complete frame reaches the latch as soon as chip select returns high. If the load input is driven, the host can preload a word and pick the moment it takes effect. A frame whose length is not exactly the word width is discarded, and a frame-error flag records it. Reset returns the latch to zero code, which is zero volts in unipolar use.

All serial pins are asynchronous to the system clock. Each pin passes through a synchronizer and is oversampled, so the serial clock must run well below the system clock.

Top module: `dac_serial_front`

## Requirements
- R1: During and after reset, `dac_code_o` is 0 and `frame_err_o` is 0.
- R2: While `cs_n_i` is low, each rising edge of `sclk_i` shifts `sdi_i` into the shift register. The first bit of a frame is bit 13 (MSB) of the word and the last bit is bit 0.
- R3: With `load_n_i` held low, a frame of exactly 14 serial clocks appears on `dac_code_o` no later than SYNC_STAGES+2 rising system-clock edges after `cs_n_i` rises.
- R4: When `cs_n_i` rises after fewer or more than 14 serial clocks (none at all counts as fewer), `dac_code_o` keeps its value and `frame_err_o` becomes 1. The flag holds until the next rise of `cs_n_i`, which sets it to 0 if that frame was complete.
- R5: A low level on `load_n_i` that ends while `cs_n_i` is still low has no effect on `dac_code_o`.
- R6: After a complete frame ends with `load_n_i` high, the word stays pending. It reaches `dac_code_o` when `load_n_i` goes low while `cs_n_i` is high.
- R7: Rising edges of `sclk_i` while `cs_n_i` is high leave the pending word unchanged.
- R8: A falling edge of `cs_n_i` discards any word still pending, so no later load pulse can move it to `dac_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock; data sampled on its rising edge |
| sdi_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Active-low latch load; may be tied low |
| dac_code_o | output | 14 | Parallel code for the converter core |
| frame_err_o | output | 1 | Set when the last frame had the wrong length |

## Verification
Two events can fall in the same cycle: the rise of chip select that closes a frame, and a low level on the load input that asks for a transfer. The bench provokes this by holding load low across the whole frame, so it is already low when chip select rises. It also pulses load only inside the frame, and only after chip select has risen. A reference model checks every cycle that the first case updates the latch exactly once and on time, that the second does nothing, and that the third moves the pending word.

// File: rtl/dac_in_pkg.sv
// Package: shared types for the serial DAC front end.
// Assumes: all consumers use the same pin bundle layout.
package dac_in_pkg;

    // Bundle of the four host-side serial pins.
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
        logic load_n;
    } serial_pins_t;

    // Idle level of the pin bundle: selects and load inactive (high).
    localparam serial_pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0, load_n: 1'b1};

endpackage

// File: rtl/dac_pin_sync.sv
// Module: dac_pin_sync
// Passes the asynchronous serial pins through a chain of STAGES flops.
// Assumes: STAGES >= 1. Reset loads the idle pin levels, so no edge is
// seen when reset ends.
module dac_pin_sync
    import dac_in_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  serial_pins_t pins_raw,
    output serial_pins_t pins_sync
);

    serial_pins_t chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= PINS_IDLE;
                    else        chain[g] <= pins_raw;
                end
            end else begin : g_next
                // Later stages: resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= PINS_IDLE;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign pins_sync = chain[STAGES-1];

endmodule

// File: rtl/dac_frame_shift.sv
// Module: dac_frame_shift
// Detects chip-select and serial-clock edges on the synchronized pins,
// shifts data MSB first and counts bits (saturating at DATA_W+1).
// Assumes: serial clock phases last at least two system clocks.
module dac_frame_shift
    import dac_in_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  serial_pins_t      pins,
    output logic [DATA_W-1:0] shift_word,
    output logic              frame_full,
    output logic              cs_rise,
    output logic              cs_fall
);

    localparam int CNT_W   = $clog2(DATA_W + 2);
    localparam int CNT_SAT = DATA_W + 1;

    logic             cs_n_q;
    logic             sclk_q;
    logic             sclk_rise;
    logic [CNT_W-1:0] bit_cnt;

    // Edge history of chip select and serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_n_q <= pins.cs_n;
            sclk_q <= pins.sclk;
        end
    end

    assign cs_rise   = pins.cs_n & ~cs_n_q;
    assign cs_fall   = ~pins.cs_n & cs_n_q;
    assign sclk_rise = pins.sclk & ~sclk_q & ~pins.cs_n;

    // Shift register: one bit in per qualified serial-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)         shift_word <= '0;
        else if (sclk_rise) shift_word <= {shift_word[DATA_W-2:0], pins.sdi};
    end

    // Bit counter: cleared at frame start, saturates past DATA_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (cs_fall)
            bit_cnt <= '0;
        else if (sclk_rise && bit_cnt != CNT_W'(CNT_SAT))
            bit_cnt <= bit_cnt + 1'b1;
    end

    assign frame_full = (bit_cnt == CNT_W'(DATA_W));

    // Shift register only moves on a qualified serial clock rise.
    AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_word != $past(shift_word)) |-> $past(sclk_rise && !pins.cs_n)); // R7

    // A frame start always clears the count.
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (bit_cnt == '0)); // R8

    // The count never passes its saturation point.
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt <= CNT_W'(CNT_SAT))); // R4

endmodule

// File: rtl/dac_latch_ctrl.sv
// Module: dac_latch_ctrl
// Holds the parallel code and the frame-error flag. A complete frame
// becomes pending at chip-select rise and moves into the code latch
// while chip select is high and load is low.
// Assumes: shift_word does not change while chip select is high.
module dac_latch_ctrl #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              load_n_s,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              frame_full,
    input  logic [DATA_W-1:0] shift_word,
    output logic [DATA_W-1:0] dac_code,
    output logic              frame_err
);

    logic pending;
    logic xfer;

    assign xfer = pending & cs_n_s & ~load_n_s;

    // Pending flag: set by a complete frame, cleared by use or new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (cs_fall)
            pending <= 1'b0;
        else if (cs_rise)
            pending <= frame_full;
        else if (xfer)
            pending <= 1'b0;
    end

    // Code latch: loads the pending word on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    dac_code <= '0;
        else if (xfer) dac_code <= shift_word;
    end

    // Frame error: judged once per frame at chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       frame_err <= 1'b0;
        else if (cs_rise) frame_err <= ~frame_full;
    end

    // The code only changes while selected-off with load asserted.
    AST_LOAD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |-> $past(cs_n_s && !load_n_s)); // R5

    // The code only changes when a complete word was pending.
    AST_LOAD_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |-> $past(pending)); // R6

    // The error flag only moves at the end of a frame.
    AST_ERR_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err != $past(frame_err)) |-> $past(cs_rise)); // R4

    // A new frame start discards the pending word.
    AST_PENDING_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !pending); // R8

endmodule

// File: rtl/dac_serial_front.sv
// Module: dac_serial_front (top)
// Three-wire serial input register and code latch of a DAC.
// Assumes: serial pins are asynchronous, serial clock phases each span
// at least SYNC_STAGES+1 system clocks.
module dac_serial_front
    import dac_in_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              load_n_i,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              frame_err_o
);

    serial_pins_t      pins_raw;
    serial_pins_t      pins_s;
    logic [DATA_W-1:0] shift_word;
    logic              frame_full;
    logic              cs_rise;
    logic              cs_fall;

    assign pins_raw = '{cs_n: cs_n_i, sclk: sclk_i, sdi: sdi_i, load_n: load_n_i};

    dac_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_raw  (pins_raw),
        .pins_sync (pins_s)
    );

    dac_frame_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins       (pins_s),
        .shift_word (shift_word),
        .frame_full (frame_full),
        .cs_rise    (cs_rise),
        .cs_fall    (cs_fall)
    );

    dac_latch_ctrl #(.DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (pins_s.cs_n),
        .load_n_s   (pins_s.load_n),
        .cs_rise    (cs_rise),
        .cs_fall    (cs_fall),
        .frame_full (frame_full),
        .shift_word (shift_word),
        .dac_code   (dac_code_o),
        .frame_err  (frame_err_o)
    );

    // Reset holds the outputs at zero code and no error.
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (dac_code_o == '0 && !frame_err_o)); // R1

endmodule

// File: tb/dac_serial_front_bench.sv
// Bench: drives host frames, runs a behavioural per-cycle model, and
// compares the code and error outputs on every clock.
module dac_serial_front_bench;

    localparam int W  = 14;
    localparam int HP = 3;   // serial half period in system clocks

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1;
    logic [W-1:0]  code;
    logic          err;

    int compared = 0, mismatched = 0, cycles = 0;
    string cur_req = "R1";

    dac_serial_front u_dac_serial_front (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
        .sdi_i(sdi), .load_n_i(load_n), .dac_code_o(code), .frame_err_o(err)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Behavioural model state (two-stage input delay, then edge logic).
    int m_code = 0, m_err = 0, m_pend = 0, m_cnt = 0, m_word = 0;
    bit d1_cs = 1, d1_sc = 0, d1_di = 0, d1_ld = 1;
    bit s_cs = 1, s_sc = 0, s_di = 0, s_ld = 1;
    bit p_cs = 1, p_sc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_err = 0; m_pend = 0; m_cnt = 0; m_word = 0;
            d1_cs = 1; d1_sc = 0; d1_di = 0; d1_ld = 1;
            s_cs = 1; s_sc = 0; s_di = 0; s_ld = 1; p_cs = 1; p_sc = 0;
        end else begin
            bit rise_c, fall_c, rise_s, go;
            rise_c = s_cs && !p_cs;
            fall_c = !s_cs && p_cs;
            rise_s = s_sc && !p_sc && !s_cs;
            go     = m_pend != 0 && s_cs && !s_ld;
            if (go) m_code = m_word;
            if (fall_c)      m_pend = 0;
            else if (rise_c) m_pend = (m_cnt == W);
            else if (go)     m_pend = 0;
            if (rise_c) m_err = (m_cnt != W);
            if (rise_s) m_word = ((m_word << 1) | s_di) & ((1 << W) - 1);
            if (fall_c) m_cnt = 0;
            else if (rise_s && m_cnt < W + 1) m_cnt++;
            p_cs = s_cs; p_sc = s_sc;
            s_cs = d1_cs; s_sc = d1_sc; s_di = d1_di; s_ld = d1_ld;
            d1_cs = cs_n; d1_sc = sclk; d1_di = sdi; d1_ld = load_n;
        end
    end

    // Per-cycle comparison, sampled away from the active edge.
    always @(negedge clk) begin
        cycles++;
        compared++;
        if (code !== W'(m_code) || err !== (m_err != 0)) begin
            mismatched++;
            $display("FAIL %s: code=%h err=%b expected code=%h err=%0d",
                     cur_req, code, err, W'(m_code), m_err);
        end
    end

    // Named point check against a value fixed by the requirements.
    task automatic check_pt(string req, logic [W-1:0] exp_code, logic exp_err);
        compared++;
        if (code !== exp_code || err !== exp_err) begin
            mismatched++;
            $display("FAIL %s: code=%h err=%b expected code=%h err=%b",
                     req, code, err, exp_code, exp_err);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbits bits taken MSB first from word (extra bits are 0).
    // ld_mode: 0 load high, 1 load low throughout, 2 load pulse mid-frame.
    task automatic send_frame(logic [W-1:0] word, int nbits, int ld_mode);
        @(negedge clk);
        load_n = (ld_mode == 1) ? 1'b0 : 1'b1;
        cs_n = 1'b0;
        wait_clk(HP);
        for (int i = 0; i < nbits; i++) begin
            sdi = (W - 1 - i >= 0) ? word[W-1-i] : 1'b0;
            if (ld_mode == 2 && i == 3) load_n = 1'b0;
            if (ld_mode == 2 && i == 6) load_n = 1'b1;
            wait_clk(HP);
            sclk = 1'b1;
            wait_clk(HP);
            sclk = 1'b0;
        end
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(10);
        load_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_clk(4);
        load_n = 1'b1;
        wait_clk(6);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        mismatched++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait_clk(5);
        cur_req = "R1";
        check_pt("R1", '0, 1'b0);
        rst_n = 1'b1;
        wait_clk(5);
        check_pt("R1", '0, 1'b0);

        cur_req = "R2/R3";
        send_frame(14'h2A5C, W, 1);
        check_pt("R2", 14'h2A5C, 1'b0);
        send_frame(14'h3FFF, W, 1);
        check_pt("R3", 14'h3FFF, 1'b0);
        send_frame(14'h0001, W, 1);
        check_pt("R2", 14'h0001, 1'b0);

        cur_req = "R4";
        send_frame(14'h1234, W - 1, 1);
        check_pt("R4", 14'h0001, 1'b1);
        send_frame(14'h1234, W + 1, 1);
        check_pt("R4", 14'h0001, 1'b1);
        send_frame(14'h0000, 0, 1);
        check_pt("R4", 14'h0001, 1'b1);
        send_frame(14'h1ABC, W, 1);
        check_pt("R4", 14'h1ABC, 1'b0);

        cur_req = "R5";
        send_frame(14'h0F0F, W, 2);
        check_pt("R5", 14'h1ABC, 1'b0);
        cur_req = "R7";
        for (int k = 0; k < 3; k++) begin
            sdi = ~sdi; sclk = 1'b1; wait_clk(HP);
            sclk = 1'b0; wait_clk(HP);
        end
        check_pt("R7", 14'h1ABC, 1'b0);
        cur_req = "R6";
        pulse_load();
        check_pt("R6", 14'h0F0F, 1'b0);
        pulse_load();
        check_pt("R6", 14'h0F0F, 1'b0);

        cur_req = "R8";
        send_frame(14'h2222, W, 0);
        check_pt("R8", 14'h0F0F, 1'b0);
        send_frame(14'h3333, 5, 0);
        check_pt("R8", 14'h0F0F, 1'b1);
        pulse_load();
        check_pt("R8", 14'h0F0F, 1'b1);

        cur_req = "R1";
        rst_n = 1'b0;
        wait_clk(3);
        check_pt("R1", '0, 1'b0);
        rst_n = 1'b1;
        wait_clk(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule